// File: doc/BRIEF.md
# Floating-Point Operand Screen and Trap Decision Unit

This block sits in front of a double-precision arithmetic or compare datapath and decides, one operand or one result check at a time, whether an invalid-operation trap must be taken. The operand is a 64-bit double word (sign in bit 63, exponent in bits 62:52, fraction in bits 51:0). It is screened according to the class of the operation that will consume it. After an operation has finished, the same unit takes that operation's exception flags. It folds them into a sticky status register, applies an ignore mask and, in software-completion mode, an enable mask, and then requests a trap if any flag survives.

Each request is presented with a single-cycle strobe. The trap request, its software-completion indicator and its six-bit exception summary are registered and pulse for one cycle. The sticky register is updated on the same clock edge that captures the strobe. The sticky register clears only on reset.

Top module: `fp_operand_screen`

## Requirements
- R1: With mode 0 (arithmetic screen), an operand with a zero exponent and a nonzero fraction raises a trap with summary 6'b000001 (invalid) and leaves the sticky register unchanged.
- R2: With mode 0, an operand with an all-ones exponent (infinity or NaN) raises a trap with summary 6'b000001 and sets sticky bit 0 (invalid).
- R3: With mode 1 (compare screen), an all-ones exponent traps and sets sticky bit 0 only when the fraction is nonzero; infinities pass; a denormal traps without touching the sticky register.
- R4: Zeros and normal numbers never trap in modes 0 and 1.
- R5: With mode 2 (software-completion screen), a nonzero operand with a zero exponent, of either sign, traps with summary 6'b000001 and the software-completion indicator set, unless flush_in is 1. Zeros, normal numbers and infinities never trap, and the sticky register is unchanged.
- R6: With mode 4 (result check), all pending flags are ORed into the sticky register. The flags left after removing the ignore mask form the summary, and a trap is raised if any remain. The software-completion indicator stays 0.
- R7: With mode 5 (software-completion result check), the ignore mask is applied first and only the surviving flags are ORed into the sticky register. A trap with the software-completion indicator is raised if any flag survives, and its summary is the survivors ANDed with the enable mask.
- R8: Flag and summary bits map one to one: bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow. Outputs appear one cycle after the strobe and last one cycle. Without the strobe, and for mode codes 3, 6 and 7, nothing traps and the sticky register holds.
- R9: Reset clears the sticky register and all trap outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| mode | input | 3 | Request class (0 arith, 1 compare, 2 sw-completion screen, 4 result, 5 sw-completion result) |
| opd | input | 64 | Double-format operand to screen |
| flush_in | input | 1 | Inputs flushed to zero; suppresses the software-completion denormal trap |
| pend | input | 6 | Exception flags raised by the finished operation |
| ign | input | 6 | Flags to drop before trapping |
| en | input | 6 | Trap enable mask for software-completion result checks |
| trap_req | output | 1 | One-cycle trap request |
| trap_swc | output | 1 | Trap carries the software-completion indicator |
| trap_sum | output | 6 | Exception summary of the trap |
| sticky | output | 6 | Accumulated sticky status flags |

## Verification
Every result of a request (trap request, indicator, summary and the new sticky value) becomes visible right after the first rising edge that sees the strobe. The bench drives each request on a falling edge, drops the strobe on the next falling edge and compares all four outputs there. It then samples once more a cycle later to confirm that the trap pulse has gone and the sticky value has held. The sticky expectation carries over from one table row to the next, so each row also checks that the accumulation across earlier requests is correct.

// File: rtl/fp_operand_screen.sv
module fp_operand_screen #(
  parameter int W     = 64,
  parameter int EXPW  = 11,
  parameter int FRACW = 52,
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       mode,
  input  logic [W-1:0]     opd,
  input  logic             flush_in,
  input  logic [NFLAG-1:0] pend,
  input  logic [NFLAG-1:0] ign,
  input  logic [NFLAG-1:0] en,
  output logic             trap_req,
  output logic             trap_swc,
  output logic [NFLAG-1:0] trap_sum,
  output logic [NFLAG-1:0] sticky
);
  localparam int EXP_LSB = W - 1 - EXPW;
  localparam logic [NFLAG-1:0] INV_BIT = NFLAG'(1);

  logic [EXPW-1:0]  expo;
  logic [FRACW-1:0] frac;
  logic             exp_zero, exp_ones, frac_nz, denorm;

  assign expo     = opd[EXP_LSB +: EXPW];
  assign frac     = opd[FRACW-1:0];
  assign exp_zero = (expo == '0);
  assign exp_ones = &expo;
  assign frac_nz  = |frac;
  assign denorm   = exp_zero & frac_nz;

  logic [NFLAG-1:0] kept;
  assign kept = pend & ~ign;

  logic             n_trap, n_swc;
  logic [NFLAG-1:0] n_sum, n_sticky;

  always_comb begin
    n_trap   = 1'b0;
    n_swc    = 1'b0;
    n_sum    = '0;
    n_sticky = sticky;
    case (mode)
      3'd0: begin
        n_trap = denorm | exp_ones;
        n_sum  = n_trap ? INV_BIT : '0;
        if (exp_ones) n_sticky = sticky | INV_BIT;
      end
      3'd1: begin
        n_trap = denorm | (exp_ones & frac_nz);
        n_sum  = n_trap ? INV_BIT : '0;
        if (exp_ones & frac_nz) n_sticky = sticky | INV_BIT;
      end
      3'd2: begin
        n_trap = denorm & ~flush_in;
        n_swc  = n_trap;
        n_sum  = n_trap ? INV_BIT : '0;
      end
      3'd4: begin
        n_sticky = sticky | pend;
        n_trap   = |kept;
        n_sum    = kept;
      end
      3'd5: begin
        n_sticky = sticky | kept;
        n_trap   = |kept;
        n_swc    = n_trap;
        n_sum    = kept & en;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      trap_swc <= 1'b0;
      trap_sum <= '0;
      sticky   <= '0;
    end else begin
      trap_req <= in_valid & n_trap;
      trap_swc <= in_valid & n_swc;
      trap_sum <= in_valid ? n_sum : '0;
      if (in_valid) sticky <= n_sticky;
    end
  end
endmodule

// File: rtl/fp_operand_screen_chk.sv
module fp_operand_screen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  mode,
  input logic [63:0] opd,
  input logic        flush_in,
  input logic [5:0]  pend,
  input logic [5:0]  ign,
  input logic [5:0]  en,
  input logic        trap_req,
  input logic        trap_swc,
  input logic [5:0]  trap_sum,
  input logic [5:0]  sticky
);
  assert_no_strobe_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !trap_req);
  assert_no_strobe_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sticky));
  assert_sticky_never_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & $past(sticky)) == $past(sticky)));
  assert_swc_needs_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_swc |-> trap_req);
  assert_cmp_inf_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd1 && (&opd[62:52]) && opd[51:0] == '0) |=> !trap_req);
  assert_result_clean_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd4 && pend == '0) |=> (!trap_req && $stable(sticky)));
  assert_swc_screen_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd2 && flush_in) |=> (!trap_req && $stable(sticky)));
  assert_screen_sum_inv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd0) |=> (trap_sum == {5'b0, trap_req}));
endmodule

bind fp_operand_screen fp_operand_screen_chk chk_i (.*);

// File: tb/fp_operand_screen_tb_top.sv
`timescale 1ns/1ps
module fp_operand_screen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [63:0] opd = '0;
  logic        flush_in = 1'b0;
  logic [5:0]  pend = '0, ign = '0, en = '0;
  logic        trap_req, trap_swc;
  logic [5:0]  trap_sum, sticky;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fp_operand_screen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .opd(opd),
    .flush_in(flush_in), .pend(pend), .ign(ign), .en(en),
    .trap_req(trap_req), .trap_swc(trap_swc), .trap_sum(trap_sum), .sticky(sticky)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  md;
    logic        fl;
    logic [63:0] op;
    logic [5:0]  pd, ig, em;
    logic        x_trap, x_swc;
    logic [5:0]  x_sum, x_sticky;
  } vec_t;

  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] DEN   = 64'h0000_0000_0000_0001;
  localparam logic [63:0] NDEN  = 64'h8000_0000_0000_0010;
  localparam logic [63:0] MAXDN = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINNR = 64'h0010_0000_0000_0000;
  localparam logic [63:0] INF   = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'd4, 3'd0, 1'b0, ONE,   6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R4
    '{4'd1, 3'd0, 1'b0, DEN,   6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 6'h01, 6'h00}, // R1
    '{4'd1, 3'd0, 1'b1, NDEN,  6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 6'h01, 6'h00}, // R1 flush no effect
    '{4'd3, 3'd1, 1'b0, INF,   6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R3
    '{4'd3, 3'd1, 1'b0, NINF,  6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R3
    '{4'd5, 3'd2, 1'b0, INF,   6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R5
    '{4'd5, 3'd2, 1'b0, DEN,   6'h00, 6'h00, 6'h00, 1'b1, 1'b1, 6'h01, 6'h00}, // R5
    '{4'd5, 3'd2, 1'b1, NDEN,  6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R5 flush
    '{4'd5, 3'd2, 1'b0, NDEN,  6'h00, 6'h00, 6'h00, 1'b1, 1'b1, 6'h01, 6'h00}, // R5 negative
    '{4'd5, 3'd2, 1'b0, NZERO, 6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R5
    '{4'd5, 3'd2, 1'b0, MAXDN, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, 6'h01, 6'h00}, // R5
    '{4'd5, 3'd2, 1'b0, MINNR, 6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R5
    '{4'd3, 3'd1, 1'b0, DEN,   6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 6'h01, 6'h00}, // R3
    '{4'd4, 3'd1, 1'b0, ONE,   6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}, // R4
    '{4'd3, 3'd1, 1'b0, QNAN,  6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 6'h01, 6'h01}, // R3
    '{4'd4, 3'd0, 1'b0, 64'h0, 6'h00, 6'h00, 6'h00, 1'b0, 1'b0, 6'h00, 6'h01}, // R4
    '{4'd6, 3'd4, 1'b0, QNAN,  6'h14, 6'h10, 6'h00, 1'b1, 1'b0, 6'h04, 6'h15}, // R6
    '{4'd6, 3'd4, 1'b0, 64'h0, 6'h10, 6'h10, 6'h3F, 1'b0, 1'b0, 6'h00, 6'h15}, // R6
    '{4'd7, 3'd5, 1'b0, 64'h0, 6'h0A, 6'h02, 6'h00, 1'b1, 1'b1, 6'h00, 6'h1D}, // R7
    '{4'd7, 3'd5, 1'b0, 64'h0, 6'h21, 6'h20, 6'h01, 1'b1, 1'b1, 6'h01, 6'h1D}, // R7
    '{4'd7, 3'd5, 1'b0, 64'h0, 6'h02, 6'h02, 6'h3F, 1'b0, 1'b0, 6'h00, 6'h1D}, // R7
    '{4'd8, 3'd3, 1'b0, QNAN,  6'h3F, 6'h00, 6'h3F, 1'b0, 1'b0, 6'h00, 6'h1D}, // R8
    '{4'd8, 3'd7, 1'b0, DEN,   6'h3F, 6'h00, 6'h3F, 1'b0, 1'b0, 6'h00, 6'h1D}  // R8
  };

  task automatic chk(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic f, input logic [63:0] o,
                       input logic [5:0] p, input logic [5:0] i, input logic [5:0] e);
    @(negedge clk);
    mode = m; flush_in = f; opd = o; pend = p; ign = i; en = e; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(9, "reset outputs", {trap_req, trap_swc, trap_sum, sticky}, 14'h0); // R9
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].md, VEC[k].fl, VEC[k].op, VEC[k].pd, VEC[k].ig, VEC[k].em);
      chk(VEC[k].rq, $sformatf("row %0d trap/swc/sum/sticky", k),
          {trap_req, trap_swc, trap_sum, sticky},
          {VEC[k].x_trap, VEC[k].x_swc, VEC[k].x_sum, VEC[k].x_sticky});
      @(negedge clk);
      chk(8, $sformatf("row %0d pulse ends, sticky holds", k), {trap_req, sticky},
          {1'b0, VEC[k].x_sticky}); // R8
    end

    // R8: flags present without strobe do nothing
    mode = 3'd4; pend = 6'h3F; ign = 6'h00; opd = QNAN;
    repeat (4) @(negedge clk);
    chk(8, "no strobe", {trap_req, sticky}, {1'b0, 6'h1D});

    // R9: reset clears sticky mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk(9, "reset clears sticky", {trap_req, trap_swc, trap_sum, sticky}, 14'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: arithmetic infinity and NaN set sticky invalid
    issue(3'd0, 1'b0, NINF, 6'h00, 6'h00, 6'h00);
    chk(2, "arith -inf", {trap_req, trap_swc, trap_sum, sticky}, {1'b1, 1'b0, 6'h01, 6'h01});
    issue(3'd0, 1'b0, QNAN, 6'h00, 6'h00, 6'h00);
    chk(2, "arith nan", {trap_req, trap_sum, sticky}, {1'b1, 6'h01, 6'h01});

    // R6: result check with nothing ignored, every flag position maps straight through
    issue(3'd4, 1'b0, 64'h0, 6'h3E, 6'h00, 6'h00);
    chk(6, "all flags kept", {trap_req, trap_swc, trap_sum, sticky}, {1'b1, 1'b0, 6'h3E, 6'h3F});

    // R8: back-to-back strobes each produce a pulse
    @(negedge clk);
    mode = 3'd0; opd = DEN; in_valid = 1'b1;
    @(negedge clk);
    chk(8, "back-to-back first", trap_req, 1'b1);
    opd = ONE;
    @(negedge clk);
    in_valid = 1'b0;
    chk(8, "back-to-back second", trap_req, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule